// File: doc/BRIEF.md
# Rename Undo Log

This block keeps an ordered record of every destination-register rename made by the rename stage of a small out-of-order core. Each record carries four fields: the instruction's sequence number, its architectural register, the physical register just allocated to it, and the physical register that mapping replaced. Because both physical registers sit in one record, a single structure serves two jobs. It frees registers at commit and it rolls the map back after a misprediction.

At commit, the oldest records whose sequence numbers are not after the committed one are retired, up to a fixed number per cycle. The replaced physical register of each retired record goes back to the free list. On a squash, the block becomes busy and walks back from the youngest record, one per cycle. Each record younger than the squash point writes its replaced register back into the rename map and hands its allocated register back to the free list. While the walk runs, new renames and commits are held off.

The log is a circular queue. Rename must stall while the full flag is high. The rename map and free list live outside the block and are driven through its output ports. Instructions without a destination register never reach the block.

Top module: `rename_undo_log`

## Requirements
- R1: After reset the log is empty: `occupancy` is 0, `full` and `busy` are 0, and no map-write, free-list return or release strobe is high.
- R2: A record is accepted when `app_valid` is high, `full`, `busy` and `sq_valid` are low. `occupancy` then rises by one at the clock edge. The four stored fields come back later on the release and undo outputs.
- R3: `full` is high exactly when `occupancy` equals DEPTH. An append offered while full is dropped and leaves `occupancy` unchanged.
- R4: A commit (`cmt_valid` with `cmt_seq`) retires records in order from the oldest. It retires at most COMMIT_W per cycle and stops at the first record whose sequence number is after `cmt_seq`. Retiring lane i carries the i-th oldest record's replaced register. The lanes are `fl_rel_valid[i]` and `fl_rel_preg[i*PREG_W +: PREG_W]`, and they are valid in the cycle after the commit edge.
- R5: When an accepted append and a commit happen at the same edge, both take effect. `occupancy` changes by one minus the number retired, and the new record is never retired in that same cycle.
- R6: A squash (`sq_valid` with `sq_seq`) raises `busy` in the next cycle. At each following edge, the youngest record whose sequence number is after `sq_seq` is undone, youngest first and one per cycle. An undo drives `map_wr_en` with that record's architectural register and replaced register, and drives `fl_ret_valid` with its allocated register. `busy` is high for n+1 cycles when n records are undone.
- R7: Appends and commits offered while `busy` is high, or in the same cycle as `sq_valid`, are dropped. They produce no release and no change to `occupancy` beyond the undo steps.
- R8: A squash with no younger record keeps `busy` high for exactly one cycle and produces no undo strobe.
- R9: With SEQ_WRAP=1, sequence number a counts as not after b when (a-b) mod 2^SEQ_W is zero or has its top bit set. Commit and squash comparisons stay correct across wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| app_valid | input | 1 | Rename offers a record |
| app_seq | input | SEQ_W | Sequence number of the renamed instruction |
| app_areg | input | AREG_W | Architectural destination register |
| app_new | input | PREG_W | Newly allocated physical register |
| app_prev | input | PREG_W | Physical register previously mapped |
| full | output | 1 | No free record; rename must stall |
| busy | output | 1 | Squash walk in progress |
| occupancy | output | $clog2(DEPTH+1) | Number of live records |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Retire records up to and including this number |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash point; younger records are undone |
| fl_rel_valid | output | COMMIT_W | Per-lane release strobe at commit |
| fl_rel_preg | output | COMMIT_W*PREG_W | Per-lane released physical register |
| map_wr_en | output | 1 | Rename map restore strobe |
| map_wr_areg | output | AREG_W | Architectural register to restore |
| map_wr_preg | output | PREG_W | Physical register written back into the map |
| fl_ret_valid | output | 1 | Free-list return strobe during undo |
| fl_ret_preg | output | PREG_W | Physical register returned by the undo |

## Verification
The bench builds the block with DEPTH=4, COMMIT_W=2 and SEQ_W=4, with wrap-aware comparison. The shallow depth makes the full condition and the dropped append easy to reach. A commit width of two, below the depth, shows a commit that is cut short by the lane limit and one that stops at a younger record. The four-bit sequence space lets the bench append numbers that cross from 15 to 0, then commit and squash across that seam. Undo ordering is exercised with two records that share one architectural register, so a wrong walk order changes the restored value.

// File: rtl/rulog_pkg.sv
package rulog_pkg;

   // True when sequence number a is not after b.
   // wrap=1: modular compare in a w-bit space; wrap=0: plain magnitude.
   function automatic logic seq_not_after(input logic [31:0] a,
                                          input logic [31:0] b,
                                          input int unsigned w,
                                          input bit          wrap);
      logic [31:0] m;
      logic [31:0] d;
      m = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      d = (a - b) & m;
      if (wrap) return (d == 32'd0) || (((d >> (w - 1)) & 32'd1) != 32'd0);
      else      return (a & m) <= (b & m);
   endfunction

endpackage

// File: rtl/rulog_store.sv
module rulog_store #(
   parameter int DEPTH  = 16,
   parameter int SEQ_W  = 8,
   parameter int AREG_W = 5,
   parameter int PREG_W = 7,
   parameter int LANES  = 2,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic                              clk,
   input  logic                              wr_en,
   input  logic [PTR_W-1:0]                  wr_idx,
   input  logic [SEQ_W-1:0]                  wr_seq,
   input  logic [AREG_W-1:0]                 wr_areg,
   input  logic [PREG_W-1:0]                 wr_new,
   input  logic [PREG_W-1:0]                 wr_prev,
   input  logic [PTR_W-1:0]                  win_base,
   output logic [LANES-1:0][SEQ_W-1:0]       win_seq,
   output logic [LANES-1:0][PREG_W-1:0]      win_prev,
   input  logic [PTR_W-1:0]                  yng_idx,
   output logic [SEQ_W-1:0]                  yng_seq,
   output logic [AREG_W-1:0]                 yng_areg,
   output logic [PREG_W-1:0]                 yng_new,
   output logic [PREG_W-1:0]                 yng_prev
);

   logic [SEQ_W-1:0]  mem_seq  [DEPTH];
   logic [AREG_W-1:0] mem_areg [DEPTH];
   logic [PREG_W-1:0] mem_new  [DEPTH];
   logic [PREG_W-1:0] mem_prev [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_seq[wr_idx]  <= wr_seq;
         mem_areg[wr_idx] <= wr_areg;
         mem_new[wr_idx]  <= wr_new;
         mem_prev[wr_idx] <= wr_prev;
      end
   end

   // Oldest-end read window, one lane per commit slot.
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_win
         logic [PTR_W-1:0] idx;
         assign idx         = win_base + PTR_W'(g);
         assign win_seq[g]  = mem_seq[idx];
         assign win_prev[g] = mem_prev[idx];
      end
   endgenerate

   // Youngest-end read port for the squash walk.
   assign yng_seq  = mem_seq[yng_idx];
   assign yng_areg = mem_areg[yng_idx];
   assign yng_new  = mem_new[yng_idx];
   assign yng_prev = mem_prev[yng_idx];

endmodule

// File: rtl/rulog_retire.sv
module rulog_retire
   import rulog_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int SEQ_W  = 8,
   parameter int PREG_W = 7,
   parameter int LANES  = 2,
   parameter bit WRAP   = 1'b1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmt_en,
   input  logic [SEQ_W-1:0]             cmt_seq,
   input  logic [CNT_W-1:0]             occ,
   input  logic [LANES-1:0][SEQ_W-1:0]  win_seq,
   input  logic [LANES-1:0][PREG_W-1:0] win_prev,
   output logic [CNT_W-1:0]             n_ret,
   output logic [LANES-1:0]             rel_valid,
   output logic [LANES-1:0][PREG_W-1:0] rel_preg
);

   logic [LANES-1:0] take;

   // Lane i retires only if every older lane retires too.
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_take
         logic in_range;
         logic old_enough;
         assign in_range   = occ > CNT_W'(g);
         assign old_enough = seq_not_after(32'(win_seq[g]), 32'(cmt_seq), SEQ_W, WRAP);
         if (g == 0) begin : g_first
            assign take[g] = cmt_en && in_range && old_enough;
         end else begin : g_rest
            assign take[g] = take[g-1] && in_range && old_enough;
         end
      end
   endgenerate

   always_comb begin
      n_ret = '0;
      for (int i = 0; i < LANES; i++) n_ret = n_ret + CNT_W'(take[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rel_valid <= '0;
         rel_preg  <= '0;
      end else begin
         rel_valid <= take;
         rel_preg  <= win_prev;
      end
   end

   AST_REL_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      ((rel_valid & (rel_valid + LANES'(1))) == '0)); // R4
   AST_RET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (n_ret <= occ)); // R4

endmodule

// File: rtl/rulog_unwind.sv
module rulog_unwind
   import rulog_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int SEQ_W  = 8,
   parameter int AREG_W = 5,
   parameter int PREG_W = 7,
   parameter bit WRAP   = 1'b1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sq_start,
   input  logic [SEQ_W-1:0]  sq_seq,
   input  logic [CNT_W-1:0]  occ,
   input  logic [SEQ_W-1:0]  yng_seq,
   input  logic [AREG_W-1:0] yng_areg,
   input  logic [PREG_W-1:0] yng_new,
   input  logic [PREG_W-1:0] yng_prev,
   output logic              busy,
   output logic              pop,
   output logic              map_wr_en,
   output logic [AREG_W-1:0] map_wr_areg,
   output logic [PREG_W-1:0] map_wr_preg,
   output logic              ret_valid,
   output logic [PREG_W-1:0] ret_preg
);

   logic [SEQ_W-1:0] point_q;
   logic             younger;

   assign younger = !seq_not_after(32'(yng_seq), 32'(point_q), SEQ_W, WRAP);
   assign pop     = busy && (occ != '0) && younger;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         point_q <= '0;
      end else if (!busy) begin
         if (sq_start) begin
            busy    <= 1'b1;
            point_q <= sq_seq;
         end
      end else if (!pop) begin
         busy <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_wr_en   <= 1'b0;
         map_wr_areg <= '0;
         map_wr_preg <= '0;
         ret_valid   <= 1'b0;
         ret_preg    <= '0;
      end else begin
         map_wr_en   <= pop;
         map_wr_areg <= yng_areg;
         map_wr_preg <= yng_prev;
         ret_valid   <= pop;
         ret_preg    <= yng_new;
      end
   end

   AST_UNDO_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      map_wr_en |-> $past(busy)); // R6
   AST_EMPTY_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && occ == '0) |=> !busy); // R8

endmodule

// File: rtl/rename_undo_log.sv
module rename_undo_log #(
   parameter int SEQ_W    = 8,
   parameter int AREG_W   = 5,
   parameter int PREG_W   = 7,
   parameter int DEPTH    = 16,
   parameter int COMMIT_W = 2,
   parameter bit SEQ_WRAP = 1'b1,
   localparam int PTR_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         app_valid,
   input  logic [SEQ_W-1:0]             app_seq,
   input  logic [AREG_W-1:0]            app_areg,
   input  logic [PREG_W-1:0]            app_new,
   input  logic [PREG_W-1:0]            app_prev,
   output logic                         full,
   output logic                         busy,
   output logic [CNT_W-1:0]             occupancy,
   input  logic                         cmt_valid,
   input  logic [SEQ_W-1:0]             cmt_seq,
   input  logic                         sq_valid,
   input  logic [SEQ_W-1:0]             sq_seq,
   output logic [COMMIT_W-1:0]          fl_rel_valid,
   output logic [COMMIT_W*PREG_W-1:0]   fl_rel_preg,
   output logic                         map_wr_en,
   output logic [AREG_W-1:0]            map_wr_areg,
   output logic [PREG_W-1:0]            map_wr_preg,
   output logic                         fl_ret_valid,
   output logic [PREG_W-1:0]            fl_ret_preg
);

   // Elaboration-time parameter checks.
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (COMMIT_W < 1 || COMMIT_W > DEPTH) begin : g_bad_cw
         $error("COMMIT_W must lie in 1..DEPTH");
      end
      if (SEQ_W < 2 || SEQ_W > 31) begin : g_bad_seq
         $error("SEQ_W must lie in 2..31");
      end
      if (SEQ_WRAP && (SEQ_W <= 31) && ((1 << (SEQ_W - 1)) < DEPTH)) begin : g_bad_span
         $error("sequence space too small for the in-flight window");
      end
   endgenerate

   logic [PTR_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] occ_q;
   logic             do_app, cmt_en, sq_start, pop;
   logic [CNT_W-1:0] n_ret;

   logic [COMMIT_W-1:0][SEQ_W-1:0]  win_seq;
   logic [COMMIT_W-1:0][PREG_W-1:0] win_prev;
   logic [COMMIT_W-1:0][PREG_W-1:0] rel_preg;
   logic [SEQ_W-1:0]  yng_seq;
   logic [AREG_W-1:0] yng_areg;
   logic [PREG_W-1:0] yng_new, yng_prev;
   logic [PTR_W-1:0]  yng_idx;

   assign full      = (occ_q == CNT_W'(DEPTH));
   assign occupancy = occ_q;
   assign sq_start  = sq_valid && !busy;
   assign do_app    = app_valid && !full && !busy && !sq_valid;
   assign cmt_en    = cmt_valid && !busy && !sq_valid;
   assign yng_idx   = tail_q - PTR_W'(1);

   rulog_store #(
      .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W), .LANES(COMMIT_W)
   ) u_store (
      .clk(clk),
      .wr_en(do_app), .wr_idx(tail_q),
      .wr_seq(app_seq), .wr_areg(app_areg), .wr_new(app_new), .wr_prev(app_prev),
      .win_base(head_q), .win_seq(win_seq), .win_prev(win_prev),
      .yng_idx(yng_idx), .yng_seq(yng_seq), .yng_areg(yng_areg),
      .yng_new(yng_new), .yng_prev(yng_prev)
   );

   rulog_retire #(
      .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PREG_W(PREG_W), .LANES(COMMIT_W), .WRAP(SEQ_WRAP)
   ) u_retire (
      .clk(clk), .rst_n(rst_n),
      .cmt_en(cmt_en), .cmt_seq(cmt_seq), .occ(occ_q),
      .win_seq(win_seq), .win_prev(win_prev),
      .n_ret(n_ret), .rel_valid(fl_rel_valid), .rel_preg(rel_preg)
   );

   assign fl_rel_preg = rel_preg;

   rulog_unwind #(
      .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W), .WRAP(SEQ_WRAP)
   ) u_unwind (
      .clk(clk), .rst_n(rst_n),
      .sq_start(sq_start), .sq_seq(sq_seq), .occ(occ_q),
      .yng_seq(yng_seq), .yng_areg(yng_areg), .yng_new(yng_new), .yng_prev(yng_prev),
      .busy(busy), .pop(pop),
      .map_wr_en(map_wr_en), .map_wr_areg(map_wr_areg), .map_wr_preg(map_wr_preg),
      .ret_valid(fl_ret_valid), .ret_preg(fl_ret_preg)
   );

   // Pointer and occupancy bookkeeping; append and retire may share an edge.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
      end else begin
         head_q <= head_q + PTR_W'(n_ret);
         tail_q <= tail_q + PTR_W'(do_app) - PTR_W'(pop);
         occ_q  <= occ_q + CNT_W'(do_app) - n_ret - CNT_W'(pop);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= CNT_W'(DEPTH)); // R3
   AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && app_valid && !cmt_valid && !busy) |=> (occ_q == CNT_W'(DEPTH))); // R3
   AST_WALK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (occ_q <= $past(occ_q))); // R7
   AST_NO_REL_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> (fl_rel_valid == '0)); // R7

endmodule

// File: tb/sim_rename_undo_log.sv
`timescale 1ns/1ps
module sim_rename_undo_log;

   localparam int SW = 4, AW = 3, PW = 5, D = 4, CW = 2, CNTW = 3;

   typedef struct packed {
      logic [SW-1:0] seq;
      logic [AW-1:0] areg;
      logic [PW-1:0] newp;
      logic [PW-1:0] prevp;
   } rec_t;

   logic clk = 0, rst_n = 0;
   logic app_valid = 0, cmt_valid = 0, sq_valid = 0;
   logic [SW-1:0] app_seq = 0, cmt_seq = 0, sq_seq = 0;
   logic [AW-1:0] app_areg = 0;
   logic [PW-1:0] app_new = 0, app_prev = 0;
   logic full, busy, map_wr_en, fl_ret_valid;
   logic [CNTW-1:0] occupancy;
   logic [CW-1:0] fl_rel_valid;
   logic [CW*PW-1:0] fl_rel_preg;
   logic [AW-1:0] map_wr_areg;
   logic [PW-1:0] map_wr_preg, fl_ret_preg;

   int checks = 0, failures = 0;
   bit done = 0;
   rec_t model[$];
   logic [PW-1:0] exp_rel[$];
   rec_t exp_undo[$];

   always #2.5 clk = ~clk;

   rename_undo_log #(.SEQ_W(SW), .AREG_W(AW), .PREG_W(PW), .DEPTH(D),
                     .COMMIT_W(CW), .SEQ_WRAP(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .app_valid(app_valid), .app_seq(app_seq), .app_areg(app_areg),
      .app_new(app_new), .app_prev(app_prev),
      .full(full), .busy(busy), .occupancy(occupancy),
      .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
      .sq_valid(sq_valid), .sq_seq(sq_seq),
      .fl_rel_valid(fl_rel_valid), .fl_rel_preg(fl_rel_preg),
      .map_wr_en(map_wr_en), .map_wr_areg(map_wr_areg), .map_wr_preg(map_wr_preg),
      .fl_ret_valid(fl_ret_valid), .fl_ret_preg(fl_ret_preg)
   );

   function automatic bit le(input logic [SW-1:0] a, input logic [SW-1:0] b);
      logic [SW-1:0] d;
      d = a - b;
      return (d == '0) || d[SW-1];
   endfunction

   task automatic expect_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: compares produced strobes against the expected queues.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int i = 0; i < CW; i++) begin
            if (fl_rel_valid[i]) begin
               checks++;
               if (exp_rel.size() == 0) begin
                  failures++;
                  $display("FAIL R4 lane%0d unexpected release actual=%0d expected=none",
                           i, fl_rel_preg[i*PW +: PW]);
               end else begin
                  logic [PW-1:0] e;
                  e = exp_rel.pop_front();
                  if (fl_rel_preg[i*PW +: PW] != e) begin
                     failures++;
                     $display("FAIL R4 lane%0d release actual=%0d expected=%0d",
                              i, fl_rel_preg[i*PW +: PW], e);
                  end
               end
            end
         end
         if (map_wr_en || fl_ret_valid) begin
            checks++;
            if (exp_undo.size() == 0) begin
               failures++;
               $display("FAIL R6 unexpected undo actual=%0d expected=none", map_wr_preg);
            end else begin
               rec_t e;
               e = exp_undo.pop_front();
               if (!(map_wr_en && fl_ret_valid) || map_wr_areg != e.areg ||
                   map_wr_preg != e.prevp || fl_ret_preg != e.newp) begin
                  failures++;
                  $display("FAIL R6 undo actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                           map_wr_areg, map_wr_preg, fl_ret_preg, e.areg, e.prevp, e.newp);
               end
            end
         end
      end
   end

   // Driver: one cycle of stimulus, with the expected results pushed to the queues.
   task automatic step(input bit a, input logic [SW-1:0] s, input logic [AW-1:0] ar,
                       input logic [PW-1:0] np, input logic [PW-1:0] pp,
                       input bit c, input logic [SW-1:0] cs,
                       input bit q, input logic [SW-1:0] qs);
      app_valid = a; app_seq = s; app_areg = ar; app_new = np; app_prev = pp;
      cmt_valid = c; cmt_seq = cs; sq_valid = q; sq_seq = qs;
      if (q) begin
         while (model.size() > 0 && !le(model[$].seq, qs))
            exp_undo.push_back(model.pop_back());
      end else begin
         int sz;
         sz = model.size();
         if (c) begin
            for (int i = 0; i < CW; i++) begin
               if (i < sz && model.size() > 0 && le(model[0].seq, cs))
                  exp_rel.push_back(model.pop_front().prevp);
               else break;
            end
         end
         if (a && sz < D) model.push_back('{s, ar, np, pp});
      end
      @(posedge clk); #1;
      app_valid = 0; cmt_valid = 0; sq_valid = 0;
   endtask

   task automatic app(input logic [SW-1:0] s, input logic [AW-1:0] ar,
                      input logic [PW-1:0] np, input logic [PW-1:0] pp);
      step(1, s, ar, np, pp, 0, 0, 0, 0);
   endtask

   // Squash and walk; R7 stimulus is offered during the first busy cycle.
   task automatic squash(input logic [SW-1:0] qs, input int n_exp, input string req);
      int cnt;
      step(0, 0, 0, 0, 0, 0, 0, 1, qs);
      expect_eq({req, " busy after squash"}, busy, 1);
      cnt = 0;
      while (busy && cnt < 20) begin
         cnt++;
         if (cnt == 1) begin
            app_valid = 1; app_seq = 9; app_areg = 1; app_new = 31; app_prev = 30;
            cmt_valid = 1; cmt_seq = qs;
         end
         @(posedge clk); #1;
         app_valid = 0; cmt_valid = 0;
      end
      expect_eq({req, " busy cycles"}, cnt, n_exp + 1);
      @(negedge clk); #1;
      expect_eq("R7 occupancy after walk", occupancy, model.size());
      expect_eq({req, " undo queue drained"}, exp_undo.size(), 0);
      expect_eq("R7 no release from dropped commit", exp_rel.size(), 0);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      expect_eq("R1 occupancy", occupancy, 0);
      expect_eq("R1 full", full, 0);
      expect_eq("R1 busy", busy, 0);
      expect_eq("R1 strobes", {fl_rel_valid, map_wr_en, fl_ret_valid}, 0);
      @(posedge clk); #1;

      // R2 appends, R3 full and dropped append
      app(1, 1, 10, 2);
      expect_eq("R2 occupancy after one append", occupancy, 1);
      app(2, 2, 11, 3);
      app(3, 3, 12, 4);
      expect_eq("R3 not full at 3", full, 0);
      app(4, 4, 13, 5);
      expect_eq("R3 full at depth", full, 1);
      app(5, 5, 14, 6);
      expect_eq("R3 append while full dropped", occupancy, 4);

      // R4 commit limited by COMMIT_W: seq 1,2 retire (prev 2,3)
      step(0, 0, 0, 0, 0, 1, 3, 0, 0);
      expect_eq("R4 occupancy after width-limited commit", occupancy, 2);
      // R5 commit of seq 3 with append of seq 5 in the same cycle
      step(1, 5, 4, 15, 13, 1, 3, 0, 0);
      expect_eq("R5 net occupancy", occupancy, 2);
      // R4 commit point older than all records retires nothing
      step(0, 0, 0, 0, 0, 1, 2, 0, 0);
      expect_eq("R4 nothing older retired", occupancy, 2);
      @(negedge clk); #1;
      expect_eq("R4 release queue drained", exp_rel.size(), 0);
      @(posedge clk); #1;

      // R6 squash undoing seq 7,6,5; seq 7 and 5 share areg 4
      app(6, 6, 16, 7);
      app(7, 4, 17, 15);
      expect_eq("R2 occupancy before squash", occupancy, 4);
      squash(4, 3, "R6");
      expect_eq("R6 occupancy after undo", occupancy, 1);

      // R8 squash with nothing younger
      squash(9, 0, "R8");
      expect_eq("R8 occupancy unchanged", occupancy, 1);

      // R9 wrap-around
      step(0, 0, 0, 0, 0, 1, 4, 0, 0);
      expect_eq("R4 last record retired", occupancy, 0);
      app(14, 0, 20, 21);
      app(15, 1, 22, 23);
      app(0, 2, 24, 25);
      app(1, 0, 26, 27);
      step(0, 0, 0, 0, 0, 1, 15, 0, 0);
      expect_eq("R9 commit across wrap stops at seq 0", occupancy, 2);
      step(0, 0, 0, 0, 0, 1, 15, 0, 0);
      expect_eq("R9 seq 0 counted after 15", occupancy, 2);
      squash(15, 2, "R9");
      expect_eq("R9 occupancy after wrapped squash", occupancy, 0);
      expect_eq("R1 not full when empty", full, 0);

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #20000;
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule